// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Recognizer

This block watches a serial bit stream, one bit per clock, and flags every point where the four most recent bits form either `1101` or `1110`. A single seven-state Moore machine tracks both patterns at once. The states are shared wherever the two patterns have a common prefix.

Matches may overlap. The last bits of one match can be the opening bits of the next, so the machine moves from a match state back into a prefix state rather than starting again from empty.

The flag is decoded from the registered state. It therefore rises in the cycle after the bit that completes a pattern. A synchronous reset returns the machine to its empty state.

The seven states and their fixed three-bit codes are:

| State | Prefix held | Code |
|---|---|---|
| `ST_IDLE` | none | 000 |
| `ST_ONE` | "1" | 001 |
| `ST_ONE_ONE` | "11" | 010 |
| `ST_P110` | "110" | 011 |
| `ST_HIT_A` | "1101" (match) | 100 |
| `ST_P111` | "111" | 101 |
| `ST_HIT_B` | "1110" (match) | 110 |

Code 111 is unused and leads to `ST_IDLE`.

The transitions are written below as input 0 / input 1:

| State | On 0 | On 1 |
|---|---|---|
| `ST_IDLE` | `ST_IDLE` | `ST_ONE` |
| `ST_ONE` | `ST_IDLE` | `ST_ONE_ONE` |
| `ST_ONE_ONE` | `ST_P110` | `ST_P111` |
| `ST_P110` | `ST_IDLE` | `ST_HIT_A` |
| `ST_HIT_A` | `ST_IDLE` | `ST_ONE_ONE` |
| `ST_P111` | `ST_HIT_B` | `ST_P111` |
| `ST_HIT_B` | `ST_IDLE` | `ST_HIT_A` |

Top module: `dual_pattern_recognizer`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters `ST_IDLE` and `match_o` reads 0 after that edge. Bits received before the reset never contribute to a later match.
- R2: When the last four bits received are 1, 1, 0, 1 (oldest first), `match_o` is 1 in the cycle after the final bit.
- R3: When the last four bits received are 1, 1, 1, 0 (oldest first), `match_o` is 1 in the cycle after the final bit.
- R4: A 1 received directly after a `1110` match completes an overlapping `1101` match, so `match_o` stays 1 for a second cycle.
- R5: After a `1101` match, its final 1 counts as the start of a new prefix. In the stream `1101101`, both the fourth and the seventh bit produce a match.
- R6: A run of any length of three or more 1s followed by a 0 produces exactly one match, in the cycle after the 0.
- R7: `match_o` is 0 for four-bit windows other than the two patterns (for example 1100, 1010 and 1011). After a match it drops to 0 unless the next bit completes another match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled every rising edge |
| match_o | output | 1 | High while the machine sits in a match state |

## Verification
The block has no tunable parameters. The bench builds it exactly as it stands, with the fixed three-bit state code.

With that build, every one of the seven states and all fourteen transitions can be reached from the serial input. The bench's stimulus table runs through all of them, including the two overlap paths and a long run of 1s.

The unused code cannot be reached from the ports. Its recovery path is guarded only by the assertion beside the state register.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'b000,
        ST_ONE     = 3'b001,
        ST_ONE_ONE = 3'b010,
        ST_P110    = 3'b011,
        ST_HIT_A   = 3'b100,
        ST_P111    = 3'b101,
        ST_HIT_B   = 3'b110
    } state_t;

endpackage

// File: rtl/dpr_next_state.sv
module dpr_next_state
    import dpr_pkg::*;
(
    input  state_t cur_i,
    input  logic   bit_i,
    output state_t nxt_o
);

    always_comb begin
        unique case (cur_i)
            ST_IDLE:    nxt_o = bit_i ? ST_ONE     : ST_IDLE;
            ST_ONE:     nxt_o = bit_i ? ST_ONE_ONE : ST_IDLE;
            ST_ONE_ONE: nxt_o = bit_i ? ST_P111    : ST_P110;
            ST_P110:    nxt_o = bit_i ? ST_HIT_A   : ST_IDLE;
            ST_HIT_A:   nxt_o = bit_i ? ST_ONE_ONE : ST_IDLE;
            ST_P111:    nxt_o = bit_i ? ST_P111    : ST_HIT_B;
            ST_HIT_B:   nxt_o = bit_i ? ST_HIT_A   : ST_IDLE;
            // unused code 111 falls back to the empty state
            default:    nxt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dpr_out_decode.sv
module dpr_out_decode
    import dpr_pkg::*;
(
    input  state_t cur_i,
    output logic   hit_o
);

    always_comb begin
        unique case (cur_i)
            ST_HIT_A, ST_HIT_B: hit_o = 1'b1;
            default:            hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dual_pattern_recognizer.sv
module dual_pattern_recognizer
    import dpr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic match_o
);

    state_t state_q;
    state_t state_d;

    dpr_next_state u_next (
        .cur_i (state_q),
        .bit_i (din),
        .nxt_o (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    dpr_out_decode u_out (
        .cur_i (state_q),
        .hit_o (match_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE) && !match_o);

    // R2
    hit_1101_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P110 && din) |=> match_o);

    // R3
    hit_1110_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P111 && !din) |=> match_o);

    // R4
    overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_B && din) |=> (match_o && state_q == ST_HIT_A));

    // R5
    reenter_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_A && din) |=> (state_q == ST_ONE_ONE));

    // R7
    no_double_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_A) |=> !match_o);

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'b111) |=> (state_q == ST_IDLE));

endmodule

// File: tb/dual_pattern_recognizer_tb_top.sv
module dual_pattern_recognizer_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_pattern_recognizer dut_i (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .match_o (match_o)
    );

    // entry: {din, expected match after that bit, requirement code}
    localparam int NVEC = 34;
    localparam logic [4:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd2}, {1'b1, 1'b0, 3'd2}, {1'b0, 1'b0, 3'd2}, {1'b1, 1'b1, 3'd2},
        {1'b0, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd3}, {1'b1, 1'b0, 3'd3}, {1'b1, 1'b0, 3'd3},
        {1'b0, 1'b1, 3'd3}, {1'b1, 1'b1, 3'd4}, {1'b1, 1'b0, 3'd5}, {1'b0, 1'b0, 3'd5},
        {1'b1, 1'b1, 3'd5}, {1'b1, 1'b0, 3'd6}, {1'b1, 1'b0, 3'd6}, {1'b1, 1'b0, 3'd6},
        {1'b1, 1'b0, 3'd6}, {1'b0, 1'b1, 3'd6}, {1'b0, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd7},
        {1'b0, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd7}, {1'b0, 1'b0, 3'd7},
        {1'b0, 1'b0, 3'd7}, {1'b0, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd7}, {1'b0, 1'b0, 3'd7},
        {1'b1, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd7}, {1'b1, 1'b0, 3'd3}, {1'b0, 1'b1, 3'd3},
        {1'b1, 1'b1, 3'd4}, {1'b0, 1'b0, 3'd7}
    };

    function automatic string req_name(input logic [2:0] code);
        case (code)
            3'd1:    return "R1";
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            3'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s match_o=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // drive a bit, let one rising edge take it, sample at the following falling edge
    task automatic step(input logic b);
        din = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200_000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        step(1'b1);
        check("R1", match_o, 1'b0);
        step(1'b1);
        check("R1", match_o, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4]);
            check(req_name(VEC[i][2:0]), match_o, VEC[i][3]);
        end

        // R1: a reset in the middle of a pattern discards the prefix
        step(1'b0);
        step(1'b1);
        step(1'b1);
        step(1'b0);
        rst = 1'b1;
        step(1'b1);
        check("R1", match_o, 1'b0);
        rst = 1'b0;
        step(1'b1);
        check("R1", match_o, 1'b0);

        // R1: a reset while the flag is high clears it
        step(1'b1);
        step(1'b0);
        step(1'b1);
        check("R2", match_o, 1'b1);
        rst = 1'b1;
        step(1'b0);
        check("R1", match_o, 1'b0);
        rst = 1'b0;

        // R2: a clean 1101 after reset
        step(1'b1);
        step(1'b1);
        step(1'b0);
        check("R2", match_o, 1'b0);
        step(1'b1);
        check("R2", match_o, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule